// File: doc/BRIEF.md
# Configuration Length-Count Tracker

This block models the completion logic of a device that takes its configuration as a serial bitstream. It runs on the configuration clock. It keeps a running tally of every qualified clock edge from the moment the program request is released. The tally includes edges that arrive before any real data. The block also watches the incoming serial data. It lets a run of all-ones fill pass, finds a short start pattern, and shifts the length field that follows into a register. Completion is flagged when the running tally equals the captured length.

Because the tally starts at release and not at the first data bit, extra clocks sent early move the finish point. If the tally has already passed the captured length by the time that length is known, completion comes only after the counter wraps around and counts up to the length a second time. A one-cycle wrap flag makes that long path visible. An optional gated mode ignores edges while a chip-select input is low. A new program request clears everything and starts over.

Top module: `cfg_len_tracker`

## Requirements
- R1: While `prog_n` is low at a clock edge, that edge clears `init_o`, `done_o`, `count_o`, `length_o` and `wrap_o` to zero.
- R2: The first edge with `prog_n` high after a clear sets `init_o` to 1 and does not count. Counting starts on the following edge.
- R3: Once `init_o` is high, every qualified edge before completion adds one to `count_o`. This includes early edges and fill bits, whatever the value of `din`.
- R4: The start pattern is the 4-bit sequence 0,0,1,0 as received, matched on a sliding window that is preset to all ones. The next `CNT_W` bits are shifted into `length_o` MSB first. Once that field is complete, `length_o` holds it until the next clear.
- R5: `done_o` cannot rise before the last length bit has been received, even when `count_o` passed the partial length earlier.
- R6: `done_o` rises on the edge where the incremented count equals the captured length. This can be the edge of the last length bit itself. While `done_o` is high, `count_o` equals `length_o`.
- R7: The counter is `CNT_W` bits wide and rolls from all ones to zero. On that rollover, `wrap_o` is high for exactly one cycle. A count that was already past the length finishes only after this rollover.
- R8: After `done_o` rises, it stays high and `count_o` stays frozen until the next clear.
- R9: With `express_en` high and `cs1` low, an edge neither counts nor shifts data. With `express_en` low, `cs1` has no effect.
- R10: Pulling `prog_n` low in the middle of a load discards the partial header and the count. The next load is then tracked from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| prog_n | input | 1 | Program request, active low, sampled on `cclk` |
| din | input | 1 | Serial configuration data |
| express_en | input | 1 | Selects the chip-select gated mode |
| cs1 | input | 1 | Chip select that gates edges in gated mode |
| init_o | output | 1 | Ready-for-data indication |
| done_o | output | 1 | Configuration complete |
| count_o | output | CNT_W | Running clock tally |
| length_o | output | CNT_W | Captured length field |
| wrap_o | output | 1 | One-cycle pulse when the tally rolls over |

## Verification
The bench builds the block with `CNT_W` set to 8. This shrinks the wrap distance from about sixteen million edges to 256, so a full rollover and second count-up fit within a few hundred clocks. With that width, the bench sweeps every early-clock count from 0 to 20. For each, it tries lengths one below, at and one above the header end, as well as zero, all ones and a later value. This covers immediate completion, normal completion and completion only after a wrap. Further runs cover the gated mode with the select low and high, and a restart in the middle of the length field.

// File: rtl/cfg_len_pkg.sv
package cfg_len_pkg;

    // Header parsing phase: hunt for the start pattern, shift the length, then hold
    typedef enum logic [1:0] {
        HDR_SEEK  = 2'd0,
        HDR_LEN   = 2'd1,
        HDR_ARMED = 2'd2
    } hdr_phase_e;

    // Start pattern as received, oldest bit in the MSB of the window
    localparam int unsigned START_W = 4;
    localparam logic [START_W-1:0] START_PAT = 4'b0010;

endpackage

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
    import cfg_len_pkg::*;
#(
    parameter int unsigned LEN_W = 24,
    parameter int unsigned PAT_W = START_W,
    parameter logic [PAT_W-1:0] PAT = START_PAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             din,
    output logic             armed_nx,
    output logic [LEN_W-1:0] len_nx,
    output logic             armed_q,
    output logic [LEN_W-1:0] len_q
);
    localparam int unsigned BIT_W = $clog2(LEN_W + 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(LEN_W - 1);

    typedef struct packed {
        hdr_phase_e       ph;
        logic [PAT_W-1:0] win;
        logic [BIT_W-1:0] nbits;
        logic [LEN_W-1:0] len;
    } prs_t;

    prs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ph    = HDR_SEEK;
            st_d.win   = '1;
            st_d.nbits = '0;
            st_d.len   = '0;
        end else if (step) begin
            unique case (st_q.ph)
                HDR_SEEK: begin
                    st_d.win = {st_q.win[PAT_W-2:0], din};
                    if (st_d.win == PAT) begin
                        st_d.ph    = HDR_LEN;
                        st_d.nbits = '0;
                        st_d.len   = '0;
                    end
                end
                HDR_LEN: begin
                    st_d.len   = {st_q.len[LEN_W-2:0], din};
                    st_d.nbits = st_q.nbits + 1'b1;
                    if (st_q.nbits == LAST_BIT) begin
                        st_d.ph = HDR_ARMED;
                    end
                end
                default: begin
                    st_d.ph = st_q.ph;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph    <= HDR_SEEK;
            st_q.win   <= '1;
            st_q.nbits <= '0;
            st_q.len   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_nx = (st_d.ph == HDR_ARMED);
    assign len_nx   = st_d.len;
    assign armed_q  = (st_q.ph == HDR_ARMED);
    assign len_q    = st_q.len;

    // R4
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && st_q.ph == HDR_ARMED) |=> (st_q.ph == HDR_ARMED && $stable(st_q.len)));

    // R5
    hdr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> ($past(st_q.ph) == HDR_LEN));

endmodule

// File: rtl/cfg_clk_tally.sv
module cfg_clk_tally #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             armed_nx,
    input  logic [CNT_W-1:0] len_nx,
    output logic             hit,
    output logic [CNT_W-1:0] count_q,
    output logic             wrap_q
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } tly_t;

    tly_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        hit       = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.wrap = (st_d.cnt == '0);
            hit       = armed_nx && (st_d.cnt == len_nx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.wrap <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.cnt;
    assign wrap_q  = st_q.wrap;

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |-> (count_q == '0));

    // R7
    wrap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && count_q == '1) |=> wrap_q);

    // R7
    wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_q |=> !wrap_q);

endmodule

// File: rtl/cfg_len_tracker.sv
module cfg_len_tracker
    import cfg_len_pkg::*;
#(
    parameter int unsigned CNT_W = 24
) (
    input  logic             cclk,
    input  logic             rst_n,
    input  logic             prog_n,
    input  logic             din,
    input  logic             express_en,
    input  logic             cs1,
    output logic             init_o,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] length_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic run;
        logic init;
        logic done;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             clr;
    logic             gated;
    logic             step;
    logic             hit;
    logic             armed_nx;
    logic             armed_q;
    logic [CNT_W-1:0] len_nx;

    assign clr   = !prog_n;
    assign gated = express_en && !cs1;
    assign step  = prog_n && st_q.run && !st_q.done && !gated;

    cfg_hdr_parser #(
        .LEN_W (CNT_W)
    ) u_parser (
        .clk      (cclk),
        .rst_n    (rst_n),
        .clr      (clr),
        .step     (step),
        .din      (din),
        .armed_nx (armed_nx),
        .len_nx   (len_nx),
        .armed_q  (armed_q),
        .len_q    (length_o)
    );

    cfg_clk_tally #(
        .CNT_W (CNT_W)
    ) u_tally (
        .clk      (cclk),
        .rst_n    (rst_n),
        .clr      (clr),
        .step     (step),
        .armed_nx (armed_nx),
        .len_nx   (len_nx),
        .hit      (hit),
        .count_q  (count_o),
        .wrap_q   (wrap_o)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.run  = 1'b0;
            st_d.init = 1'b0;
            st_d.done = 1'b0;
        end else begin
            if (!st_q.run) begin
                st_d.run  = 1'b1;
                st_d.init = 1'b1;
            end
            st_d.done = st_q.done || hit;
        end
    end

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run  <= 1'b0;
            st_q.init <= 1'b0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign init_o = st_q.init;
    assign done_o = st_q.done;

    // R1
    clear_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        !prog_n |=> (!init_o && !done_o && count_o == '0 && length_o == '0 && !wrap_o));

    // R2
    init_rise_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        (prog_n && !init_o) |=> (init_o && $stable(count_o)));

    // R5
    done_armed_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        done_o |-> armed_q);

    // R6
    done_match_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        done_o |-> (count_o == length_o));

    // R8
    done_hold_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        (done_o && prog_n) |=> (done_o && $stable(count_o)));

    // R9
    gate_idle_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        (prog_n && express_en && !cs1) |=> ($stable(count_o) && $stable(length_o)));

endmodule

// File: tb/cfg_len_tracker_test.sv
module cfg_len_tracker_test;
    localparam int W   = 8;
    localparam int MOD = 1 << W;

    logic         cclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prog_n = 1'b0;
    logic         din = 1'b1;
    logic         express_en = 1'b0;
    logic         cs1 = 1'b1;
    logic         init_o, done_o, wrap_o;
    logic [W-1:0] count_o, length_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 cclk = ~cclk;

    cfg_len_tracker #(.CNT_W(W)) uut (
        .cclk       (cclk),
        .rst_n      (rst_n),
        .prog_n     (prog_n),
        .din        (din),
        .express_en (express_en),
        .cs1        (cs1),
        .init_o     (init_o),
        .done_o     (done_o),
        .count_o    (count_o),
        .length_o   (length_o),
        .wrap_o     (wrap_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge cclk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            report();
        end
    end

    task automatic tick();
        @(posedge cclk);
        @(negedge cclk);
    endtask

    task automatic send(input logic b);
        din = b;
        tick();
    endtask

    // R1 clear, R2 init rise without counting
    task automatic prog_pulse();
        prog_n = 1'b0;
        tick();
        tick();
        chk("R1 init", int'(init_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 count", int'(count_o), 0);
        chk("R1 length", int'(length_o), 0);
        chk("R1 wrap", int'(wrap_o), 0);
        prog_n = 1'b1;
        din = 1'b1;
        tick();
        chk("R2 init", int'(init_o), 1);
        chk("R2 count", int'(count_o), 0);
    endtask

    task automatic send_header(input int len);
        for (int i = 0; i < 4; i++) send(1'b1);
        send(1'b0); send(1'b0); send(1'b1); send(1'b0);
        for (int i = W - 1; i >= 0; i--) send(len[i]);
    endtask

    // Finish after header: expect (len - hdr) mod 2^W more edges, one wrap iff len < hdr
    task automatic finish_run(input int hdr, input int len);
        int n = 0;
        int w = 0;
        int exp_n;
        exp_n = ((len - hdr) % MOD + MOD) % MOD;
        chk("R4 length", int'(length_o), len);
        chk("R3 count after header", int'(count_o), hdr % MOD);
        chk("R5 R6 done at header end", int'(done_o), (len == hdr) ? 1 : 0);
        if (!done_o) begin
            for (int k = 0; k < 300; k++) begin
                send(1'b0);
                n++;
                if (wrap_o) w++;
                if (done_o) break;
            end
            chk("R6 done reached", int'(done_o), 1);
            chk("R6 R7 edges to done", n, exp_n);
            chk("R7 wraps", w, (len < hdr) ? 1 : 0);
        end
        chk("R6 count equals length", int'(count_o), len);
        for (int k = 0; k < 3; k++) send(k[0]);
        chk("R8 done held", int'(done_o), 1);
        chk("R8 count frozen", int'(count_o), len);
    endtask

    task automatic run_case(input int early, input int len);
        prog_pulse();
        for (int i = 0; i < early; i++) send(1'b1);
        send_header(len);
        finish_run(early + 8 + W, len);
    endtask

    initial begin
        tick();
        tick();
        chk("R1 reset done", int'(done_o), 0);
        chk("R1 reset count", int'(count_o), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 held by prog", int'(init_o), 0);

        // Sweep of early clocks against lengths around the header end
        for (int e = 0; e <= 20; e++) begin
            int hdr;
            hdr = e + 8 + W;
            run_case(e, hdr - 1);
            run_case(e, hdr);
            run_case(e, hdr + 1);
            run_case(e, 0);
            run_case(e, MOD - 1);
            run_case(e, hdr + 37);
        end

        // R9 gated mode: edges with select low are ignored
        express_en = 1'b1;
        cs1 = 1'b1;
        prog_pulse();
        for (int i = 0; i < 3; i++) send(1'b1);
        cs1 = 1'b0;
        for (int i = 0; i < 7; i++) send(1'b0);
        chk("R9 gated count", int'(count_o), 3);
        chk("R9 gated length", int'(length_o), 0);
        cs1 = 1'b1;
        send_header(40);
        finish_run(3 + 8 + W, 40);

        // R9 select has no effect when gated mode is off
        express_en = 1'b0;
        cs1 = 1'b0;
        prog_pulse();
        send_header(50);
        finish_run(8 + W, 50);
        cs1 = 1'b1;

        // R10 restart in the middle of the length field
        prog_pulse();
        for (int i = 0; i < 4; i++) send(1'b1);
        send(1'b0); send(1'b0); send(1'b1); send(1'b0);
        send(1'b1); send(1'b1); send(1'b0);
        chk("R10 count before restart", int'(count_o), 11);
        prog_n = 1'b0;
        tick();
        chk("R10 count cleared", int'(count_o), 0);
        chk("R10 length cleared", int'(length_o), 0);
        chk("R10 init cleared", int'(init_o), 0);
        run_case(2, 60);

        report();
    end
endmodule